// File: doc/BRIEF.md
# LCD Scanline Timing Generator

This block produces the line and frame rhythm of a 160x144 handheld LCD controller from a dot-cycle clock. Two counters track the dot position inside the current line (456 dots) and the line inside the frame (154 lines, 70224 dots per frame). A state machine follows these counters through the phases of a line. It drives a 2-bit mode code and issues single-cycle requests at the start of horizontal blank on visible lines and at the start of vertical blank.

A read port returns the current-line value that software observes. This value is not always the internal line number. On the last internal line (153), the port shows 153 for only the first 4 dots and 0 for the rest of the line. Software therefore sees line 0 for 908 consecutive dots, while the mode and request timing keep following the internal counter. Drawing is modelled as a fixed 80-dot object-scan phase followed by a fixed 172-dot transfer phase. Horizontal blank fills the remaining 204 dots.

The state machine has five states. ST_OFF is the display-disabled state. ST_OAM is the object scan (dots 0 to 79). ST_XFER is the pixel transfer (dots 80 to 251). ST_HBLANK covers dots 252 to 455. ST_VBLANK covers lines 144 to 153. Transitions:
- OFF to OAM on the first clock edge with enable high.
- OAM to XFER at dot 79.
- XFER to HBLANK at dot 251.
- HBLANK to OAM at dot 455 on lines 0 to 142.
- HBLANK to VBLANK at dot 455 of line 143.
- VBLANK to OAM at dot 455 of line 153.
- Any state to OFF when enable is low at a clock edge.

Top module: `lcd_line_timer`

## Requirements
- R1: A line lasts 456 dot cycles and a frame has 154 lines; the full pattern of outputs repeats every 70224 cycles.
- R2: On lines 0 to 143, mode is 2 for dots 0 to 79, 3 for dots 80 to 251 and 0 for dots 252 to 455.
- R3: On lines 144 to 153, mode is 1 for the whole line.
- R4: hblank_req is high for exactly one cycle at dot 252 of each line 0 to 143 and never during lines 144 to 153, giving 144 pulses per frame.
- R5: vblank_req is high for exactly one cycle, at dot 0 of line 144, once per frame.
- R6: On lines 0 to 152, the line value shown equals the internal line number.
- R7: On internal line 153, the line value is 153 for dots 0 to 3 and 0 for dots 4 to 455, so it reads 0 for 908 consecutive cycles across the frame wrap.
- R8: When ly_rd is high, ly_data carries the line value; when ly_rd is low, ly_data is 0.
- R9: After a clock edge with lcd_en low, mode is 0, the line value is 0 and no request is raised.
- R10: The first clock edge with lcd_en high after a disabled period starts line 0 at dot 0 in mode 2, and timing runs from there.
- R11: While rst_n is low, the block behaves as disabled: mode 0, line value 0, no requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot-cycle clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lcd_en | input | 1 | Display enable; low holds all timing at zero |
| ly_rd | input | 1 | Read strobe for the line value |
| ly_data | output | 8 | Current line value as seen by software, 0 when not read |
| mode | output | 2 | 0 hblank, 1 vblank, 2 object scan, 3 transfer |
| hblank_req | output | 1 | One-cycle horizontal-blank request |
| vblank_req | output | 1 | One-cycle vertical-blank request |

## Verification
The bench runs a cycle-count reference model over two full frames and compares every output on every cycle. This exposes any design whose line length or phase boundaries are off by one, because its mode edges would slide. The line-153 window gets close attention. A design that shows 153 for the whole line, or switches to 0 one dot early or late, breaks the 908-cycle run of zeros measured across the frame wrap. Pulse counts per frame catch horizontal-blank requests that leak into vertical blank and vertical-blank requests that repeat. A mid-frame disable and re-enable checks that the block restarts at line 0, dot 0, rather than resuming from where it stopped.

// File: rtl/lcd_timing_pkg.sv
package lcd_timing_pkg;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_OAM,
        ST_XFER,
        ST_HBLANK,
        ST_VBLANK
    } lcd_state_e;

    localparam logic [1:0] MODE_HBLANK = 2'd0;
    localparam logic [1:0] MODE_VBLANK = 2'd1;
    localparam logic [1:0] MODE_OAM    = 2'd2;
    localparam logic [1:0] MODE_XFER   = 2'd3;

endpackage

// File: rtl/lcd_dot_counter.sv
module lcd_dot_counter #(
    parameter int unsigned DOTS = 456,
    parameter int unsigned W    = $clog2(DOTS)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         advance,
    output logic [W-1:0] dot,
    output logic         line_end
);

    localparam logic [W-1:0] LAST_DOT = W'(DOTS - 1);

    assign line_end = (dot == LAST_DOT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dot <= '0;
        end else if (!advance) begin
            dot <= '0;
        end else if (line_end) begin
            dot <= '0;
        end else begin
            dot <= dot + 1'b1;
        end
    end

endmodule

// File: rtl/lcd_line_counter.sv
module lcd_line_counter #(
    parameter int unsigned LINES = 154,
    parameter int unsigned W     = $clog2(LINES)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         advance,
    input  logic         step,
    output logic [W-1:0] line,
    output logic         frame_last
);

    localparam logic [W-1:0] LAST_LINE = W'(LINES - 1);

    assign frame_last = (line == LAST_LINE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line <= '0;
        end else if (!advance) begin
            line <= '0;
        end else if (step) begin
            line <= frame_last ? '0 : line + 1'b1;
        end
    end

endmodule

// File: rtl/lcd_mode_fsm.sv
module lcd_mode_fsm
    import lcd_timing_pkg::*;
#(
    parameter int unsigned DOTS_PER_LINE = 456,
    parameter int unsigned VISIBLE_LINES = 144,
    parameter int unsigned OAM_DOTS      = 80,
    parameter int unsigned XFER_DOTS     = 172,
    parameter int unsigned DOT_W         = 9,
    parameter int unsigned LINE_W        = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lcd_en,
    input  logic [DOT_W-1:0]  dot,
    input  logic [LINE_W-1:0] line,
    input  logic              line_end,
    input  logic              frame_last,
    output logic              advance,
    output logic [1:0]        mode,
    output logic              hblank_req,
    output logic              vblank_req
);

    localparam logic [DOT_W-1:0]  OAM_LAST  = DOT_W'(OAM_DOTS - 1);
    localparam logic [DOT_W-1:0]  XFER_LAST = DOT_W'(OAM_DOTS + XFER_DOTS - 1);
    localparam logic [LINE_W-1:0] VIS_LAST  = LINE_W'(VISIBLE_LINES - 1);

    lcd_state_e state, state_nxt;

    // counters run only once the machine has left the disabled state
    assign advance = lcd_en && (state != ST_OFF);

    always_comb begin
        state_nxt = state;
        if (!lcd_en) begin
            state_nxt = ST_OFF;
        end else begin
            unique case (state)
                ST_OFF:    state_nxt = ST_OAM;
                ST_OAM:    if (dot == OAM_LAST)  state_nxt = ST_XFER;
                ST_XFER:   if (dot == XFER_LAST) state_nxt = ST_HBLANK;
                ST_HBLANK: if (line_end)
                               state_nxt = (line == VIS_LAST) ? ST_VBLANK : ST_OAM;
                ST_VBLANK: if (line_end && frame_last) state_nxt = ST_OAM;
                default:   state_nxt = ST_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_OFF;
        end else begin
            state <= state_nxt;
        end
    end

    // request pulses are registered from the transitions that open each blank
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hblank_req <= 1'b0;
            vblank_req <= 1'b0;
        end else begin
            hblank_req <= (state == ST_XFER) && (state_nxt == ST_HBLANK);
            vblank_req <= (state == ST_HBLANK) && (state_nxt == ST_VBLANK);
        end
    end

    always_comb begin
        unique case (state)
            ST_OAM:    mode = MODE_OAM;
            ST_XFER:   mode = MODE_XFER;
            ST_VBLANK: mode = MODE_VBLANK;
            default:   mode = MODE_HBLANK;
        endcase
    end

endmodule

// File: rtl/lcd_ly_view.sv
module lcd_ly_view #(
    parameter int unsigned LINES_PER_FRAME = 154,
    parameter int unsigned LAST_LINE_SHOW  = 4,
    parameter int unsigned DOT_W           = 9,
    parameter int unsigned LINE_W          = 8
) (
    input  logic [DOT_W-1:0]  dot,
    input  logic [LINE_W-1:0] line,
    input  logic              ly_rd,
    output logic [LINE_W-1:0] ly_data
);

    localparam logic [LINE_W-1:0] LAST_LINE = LINE_W'(LINES_PER_FRAME - 1);
    localparam logic [DOT_W-1:0]  SHOW_END  = DOT_W'(LAST_LINE_SHOW);

    logic [LINE_W-1:0] ly_visible;

    // the last line folds to zero early; the internal counter is untouched
    always_comb begin
        if ((line == LAST_LINE) && (dot >= SHOW_END)) begin
            ly_visible = '0;
        end else begin
            ly_visible = line;
        end
    end

    assign ly_data = ly_rd ? ly_visible : '0;

endmodule

// File: rtl/lcd_line_timer.sv
module lcd_line_timer #(
    parameter int unsigned DOTS_PER_LINE   = 456,
    parameter int unsigned LINES_PER_FRAME = 154,
    parameter int unsigned VISIBLE_LINES   = 144,
    parameter int unsigned OAM_DOTS        = 80,
    parameter int unsigned XFER_DOTS       = 172,
    parameter int unsigned LAST_LINE_SHOW  = 4,
    parameter int unsigned DOT_W           = $clog2(DOTS_PER_LINE),
    parameter int unsigned LINE_W          = $clog2(LINES_PER_FRAME)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lcd_en,
    input  logic              ly_rd,
    output logic [LINE_W-1:0] ly_data,
    output logic [1:0]        mode,
    output logic              hblank_req,
    output logic              vblank_req
);

    logic [DOT_W-1:0]  dot;
    logic [LINE_W-1:0] line;
    logic              advance;
    logic              line_end;
    logic              frame_last;

    lcd_dot_counter #(
        .DOTS (DOTS_PER_LINE),
        .W    (DOT_W)
    ) u_dot (
        .clk      (clk),
        .rst_n    (rst_n),
        .advance  (advance),
        .dot      (dot),
        .line_end (line_end)
    );

    lcd_line_counter #(
        .LINES (LINES_PER_FRAME),
        .W     (LINE_W)
    ) u_line (
        .clk        (clk),
        .rst_n      (rst_n),
        .advance    (advance),
        .step       (line_end),
        .line       (line),
        .frame_last (frame_last)
    );

    lcd_mode_fsm #(
        .DOTS_PER_LINE (DOTS_PER_LINE),
        .VISIBLE_LINES (VISIBLE_LINES),
        .OAM_DOTS      (OAM_DOTS),
        .XFER_DOTS     (XFER_DOTS),
        .DOT_W         (DOT_W),
        .LINE_W        (LINE_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .lcd_en     (lcd_en),
        .dot        (dot),
        .line       (line),
        .line_end   (line_end),
        .frame_last (frame_last),
        .advance    (advance),
        .mode       (mode),
        .hblank_req (hblank_req),
        .vblank_req (vblank_req)
    );

    lcd_ly_view #(
        .LINES_PER_FRAME (LINES_PER_FRAME),
        .LAST_LINE_SHOW  (LAST_LINE_SHOW),
        .DOT_W           (DOT_W),
        .LINE_W          (LINE_W)
    ) u_ly (
        .dot     (dot),
        .line    (line),
        .ly_rd   (ly_rd),
        .ly_data (ly_data)
    );

endmodule

// File: rtl/lcd_line_timer_chk.sv
module lcd_line_timer_chk #(
    parameter int unsigned LINE_W = 8,
    parameter int unsigned LINES  = 154
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lcd_en,
    input logic              ly_rd,
    input logic [LINE_W-1:0] ly_data,
    input logic [1:0]        mode,
    input logic              hblank_req,
    input logic              vblank_req
);

    // R4: horizontal-blank request lasts a single cycle and lands in mode 0
    p_hblank_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        hblank_req |=> !hblank_req);
    p_hblank_mode_r4: assert property (@(posedge clk) disable iff (!rst_n)
        hblank_req |-> (mode == 2'd0));

    // R5: vertical-blank request coincides with mode 1, after a hblank cycle, line 144
    p_vblank_mode_r5: assert property (@(posedge clk) disable iff (!rst_n)
        vblank_req |-> (mode == 2'd1) && ($past(mode) == 2'd0));
    p_vblank_line_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (vblank_req && ly_rd) |-> (ly_data == LINE_W'(144)));

    // R2: transfer is followed only by transfer or horizontal blank
    p_xfer_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd3) |=> (mode == 2'd3) || (mode == 2'd0));

    // R6: the line value never leaves the frame range
    p_ly_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ly_data < LINE_W'(LINES));

    // R8: no read, no data
    p_rd_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !ly_rd |-> (ly_data == '0));

    // R9: disabled edge clears everything seen at the ports
    p_disabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !lcd_en |=> (mode == 2'd0) && !hblank_req && !vblank_req && (ly_data == '0));

    // R10: enabling starts in object scan
    p_enable_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(lcd_en) ##1 lcd_en) |=> (mode == 2'd2));

endmodule

bind lcd_line_timer lcd_line_timer_chk #(
    .LINE_W (LINE_W),
    .LINES  (LINES_PER_FRAME)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .lcd_en     (lcd_en),
    .ly_rd      (ly_rd),
    .ly_data    (ly_data),
    .mode       (mode),
    .hblank_req (hblank_req),
    .vblank_req (vblank_req)
);

// File: tb/test_lcd_line_timer.sv
module test_lcd_line_timer;

    localparam int FRAME = 70224;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       lcd_en;
    logic       ly_rd;
    logic [7:0] ly_data;
    logic [1:0] mode;
    logic       hblank_req;
    logic       vblank_req;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // reference model state
    bit on = 0;
    int k  = 0;
    int hb_cnt = 0;
    int vb_cnt = 0;
    int zrun   = 0;
    int frame_checks = 0;
    int run_checks   = 0;

    always #10 clk = ~clk;

    lcd_line_timer i_lcd_line_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .lcd_en     (lcd_en),
        .ly_rd      (ly_rd),
        .ly_data    (ly_data),
        .mode       (mode),
        .hblank_req (hblank_req),
        .vblank_req (vblank_req)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            if (errors < 20)
                $display("FAIL %s: actual=%0d expected=%0d (on=%0d k=%0d)", req, act, exp, on, k);
        end
    endtask

    // model advance: position since the first enabled edge
    always @(posedge clk) begin
        if (!rst_n || !lcd_en) begin
            on = 0;
            k  = 0;
        end else if (!on) begin
            on = 1;
            k  = 0;
        end else begin
            k = (k + 1) % FRAME;
        end
    end

    always @(negedge clk) begin
        int ln, dt, e_mode, e_ly, e_data;
        bit e_hb, e_vb;
        if (!done) begin
            ln = k / 456;
            dt = k % 456;
            if (!on) begin
                e_mode = 0; e_ly = 0; e_hb = 0; e_vb = 0;
            end else begin
                if (ln >= 144)      e_mode = 1;
                else if (dt < 80)   e_mode = 2;
                else if (dt < 252)  e_mode = 3;
                else                e_mode = 0;
                e_ly = (ln == 153 && dt >= 4) ? 0 : ln;
                e_hb = (ln < 144) && (dt == 252);
                e_vb = (ln == 144) && (dt == 0);
            end
            e_data = ly_rd ? e_ly : 0;
            if (!on) begin
                chk(mode == 2'(e_mode), "R9/R11 mode", int'(mode), e_mode);
                chk(ly_data == 8'(e_data), "R9/R11 ly", int'(ly_data), e_data);
                chk(!hblank_req && !vblank_req, "R9/R11 req", int'({hblank_req, vblank_req}), 0);
            end else begin
                chk(mode == 2'(e_mode), (ln >= 144) ? "R3 mode" : "R2 mode", int'(mode), e_mode);
                chk(ly_data == 8'(e_data),
                    (ln == 153) ? "R7 ly" : (ly_rd ? "R6 ly" : "R8 ly"), int'(ly_data), e_data);
                chk(hblank_req == e_hb, "R4 hblank", int'(hblank_req), int'(e_hb));
                chk(vblank_req == e_vb, "R5 vblank", int'(vblank_req), int'(e_vb));
                if (k == 0) chk(mode == 2'd2 && ly_data == 8'(e_data), "R10 start", int'(mode), 2);
                // per-frame pulse totals (R1 frame length, R4, R5)
                if (k == 0) begin hb_cnt = 0; vb_cnt = 0; end
                if (hblank_req) hb_cnt++;
                if (vblank_req) vb_cnt++;
                if (k == FRAME - 1) begin
                    chk(hb_cnt == 144, "R4 hblank count", hb_cnt, 144);
                    chk(vb_cnt == 1, "R5 vblank count", vb_cnt, 1);
                    chk(mode == 2'd1, "R1 frame end mode", int'(mode), 1);
                    frame_checks++;
                end
            end
            // zero run across the frame wrap (R7)
            if (on && ly_rd) begin
                if (ly_data == 8'd0) zrun++;
                else begin
                    if (zrun > 456) begin
                        chk(zrun == 908, "R7 zero run", zrun, 908);
                        run_checks++;
                    end
                    zrun = 0;
                end
            end else begin
                zrun = 0;
            end
        end
    end

    initial begin
        rst_n  = 1'b0;
        lcd_en = 1'b0;
        ly_rd  = 1'b1;
        repeat (5) @(posedge clk);
        #2 rst_n = 1'b1;
        repeat (5) @(posedge clk);
        #2 lcd_en = 1'b1;
        for (int i = 0; i < 2 * FRAME + 500; i++) begin
            @(posedge clk);
            #2 ly_rd = (i >= 1000 && i < 1300) ? i[0] : 1'b1;
        end
        // mid-frame disable then restart (R9, R10)
        lcd_en = 1'b0;
        repeat (20) @(posedge clk);
        #2 lcd_en = 1'b1;
        repeat (1200) @(posedge clk);
        #2;
        @(negedge clk);
        chk(frame_checks == 2, "R1 frames seen", frame_checks, 2);
        chk(run_checks == 2, "R7 runs seen", run_checks, 2);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule